// File: doc/BRIEF.md
# Update Rectangle Transfer Splitter

This block accepts one screen-update request (a rectangle given by x, y, width and height, a pixel colour mode and a tear-sync flag) and breaks it into an ordered series of sub-transfer descriptors. Each descriptor leaves the block on a valid/ready handshake, one at a time. A display path that moves two pixels per bus beat can then handle each descriptor on its own.

A column that starts on an odd x becomes a one-pixel-wide strip. So does a single column left over at the right edge. The even-width span between them is sent as one piece if its byte count (two bytes per pixel) fits the programmable transfer budget. Otherwise it is cut into an upper piece whose height is the budget divided by the span's bytes per row, and a lower piece that holds the remaining rows. A sequential divider computes that height, and the block waits for it. Only the first piece keeps the tear-sync flag. The final piece carries a last flag, and a one-cycle done pulse follows its acceptance.

Top module: `rect_splitter`

## Requirements
- R1: After reset, desc_valid_o, done_o and err_o are low and req_ready_o is high.
- R2: When x is odd, and width and height are non-zero, the first descriptor is a one-pixel-wide column at (x, y) with the full height. The rest of the request then starts at x+1 with width reduced by one.
- R3: The middle span has the remaining width with bit 0 cleared. It starts at the updated x and is emitted as a single piece of full height when span*height*2 does not exceed max_len_i. No middle piece is emitted when that width is zero.
- R4: When span*height*2 exceeds max_len_i and height is at least 2, the middle span becomes two pieces. The first is at the request's y, with height max_len_i/(2*span) rounded down (a quotient of 0 becomes 1). The second holds the remaining rows directly below it. A height of 1 is never split.
- R5: A single column left after the middle span becomes the final descriptor: width 1 at x_orig+width_orig-1, at the original y, with the full height.
- R6: desc_tsync_o equals req_tsync_i on the first descriptor of a request and is 0 on every later descriptor of that request.
- R7: Mode codes 0 (RGB565), 1 (YUV422) and 2 (YUV420) are passed unchanged on desc_mode_o. Code 3 is rejected: no descriptor is emitted, and err_o and done_o pulse together for one cycle.
- R8: A request with zero width or zero height emits no descriptor and produces one done_o pulse without err_o.
- R9: desc_last_o is 1 only on the final descriptor of a request. done_o pulses once, for one cycle, after that descriptor is accepted, and no descriptor is valid while done_o is high.
- R10: While desc_valid_o is high and desc_ready_i is low, the descriptor stays valid and all of its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can take a request |
| req_x_i | input | CW | Rectangle left column |
| req_y_i | input | CW | Rectangle top row |
| req_w_i | input | CW | Rectangle width in pixels |
| req_h_i | input | CW | Rectangle height in rows |
| req_mode_i | input | 2 | Colour mode code |
| req_tsync_i | input | 1 | Tear-sync requested |
| max_len_i | input | LW | Transfer budget in bytes, sampled with the request |
| desc_valid_o | output | 1 | Descriptor present |
| desc_ready_i | input | 1 | Downstream takes the descriptor |
| desc_x_o | output | CW | Piece left column |
| desc_y_o | output | CW | Piece top row |
| desc_w_o | output | CW | Piece width |
| desc_h_o | output | CW | Piece height |
| desc_mode_o | output | 2 | Colour mode code |
| desc_tsync_o | output | 1 | Tear-sync for this piece |
| desc_last_o | output | 1 | Final piece of the request |
| done_o | output | 1 | One-cycle pulse at request end |
| err_o | output | 1 | One-cycle pulse for a rejected mode |

## Verification
The bench uses the default CW=11 and LW=20. With a 20-bit budget, random budgets fall on both sides of span*height*2 for spans and heights up to 1023, so split and unsplit middles both occur often. Small budgets below 2*span drive the divider to a zero quotient. The 20-cycle divider latency and a randomly stalled downstream show the stall and hold behaviour across many request shapes.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PLAN, S_LEAD, S_MCHK, S_DIV, S_MIDA, S_MIDB, S_MID, S_TAIL, S_EMPTY, S_ERR
  } rs_state_e;

  localparam logic [1:0] MODE_RGB565 = 2'd0;
  localparam logic [1:0] MODE_YUV422 = 2'd1;
  localparam logic [1:0] MODE_YUV420 = 2'd2;

  function automatic logic mode_ok(input logic [1:0] m);
    return (m == MODE_RGB565) || (m == MODE_YUV422) || (m == MODE_YUV420);
  endfunction
endpackage

// File: rtl/rs_div.sv
// Restoring divider, one quotient bit per cycle.
module rs_div #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, quo_q, dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;
  logic [W:0]       shifted;

  assign shifted = {rem_q, quo_q[W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      quo_q  <= dividend_i;
      dvs_q  <= divisor_i;
      cnt_q  <= CNT_W'(W);
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q) begin
      if (shifted >= {1'b0, dvs_q}) begin
        rem_q <= W'(shifted - {1'b0, dvs_q});
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
endmodule

// File: rtl/rs_out_slot.sv
// Single output register on a valid/ready handshake.
module rs_out_slot #(
  parameter int DW = 48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic          free_o,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [DW-1:0] data_o
);
  logic          vld_q;
  logic [DW-1:0] dat_q;

  assign free_o = !vld_q || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (load_i) begin
      vld_q <= 1'b1;
      dat_q <= data_i;
    end else if (ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign valid_o = vld_q;
  assign data_o  = dat_q;
endmodule

// File: rtl/rect_splitter.sv
module rect_splitter #(
  parameter int CW = 11,
  parameter int LW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [CW-1:0] req_x_i,
  input  logic [CW-1:0] req_y_i,
  input  logic [CW-1:0] req_w_i,
  input  logic [CW-1:0] req_h_i,
  input  logic [1:0]    req_mode_i,
  input  logic          req_tsync_i,
  input  logic [LW-1:0] max_len_i,
  output logic          desc_valid_o,
  input  logic          desc_ready_i,
  output logic [CW-1:0] desc_x_o,
  output logic [CW-1:0] desc_y_o,
  output logic [CW-1:0] desc_w_o,
  output logic [CW-1:0] desc_h_o,
  output logic [1:0]    desc_mode_o,
  output logic          desc_tsync_o,
  output logic          desc_last_o,
  output logic          done_o,
  output logic          err_o
);
  import rs_pkg::*;

  localparam int DW   = 4 * CW + 4;
  localparam int PW   = 2 * CW + 2;
  localparam int CMPW = (PW > LW) ? PW : LW;

  rs_state_e     state_q;
  logic [CW-1:0] x_q, y_q, w_q, h_q, ytop_q;
  logic [1:0]    mode_q;
  logic          first_q;
  logic [LW-1:0] max_q;
  logic          done_q, err_q;

  logic [CW-1:0] xspan;
  logic [PW-1:0] bytes_need;
  logic          oversize;
  logic          div_start, div_done;
  logic [LW-1:0] div_quot;

  logic          slot_free, load, slot_valid;
  logic [CW-1:0] d_x, d_y, d_w, d_h;
  logic          d_last;
  logic [DW-1:0] slot_out;

  assign xspan      = {w_q[CW-1:1], 1'b0};
  assign bytes_need = (PW'(xspan) * PW'(h_q)) << 1;
  assign oversize   = (CMPW'(bytes_need) > CMPW'(max_q)) && (h_q > CW'(1));
  assign div_start  = (state_q == S_MCHK) && (xspan != '0) && oversize;

  rs_div #(.W(LW)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (max_q),
    .divisor_i  (LW'({xspan, 1'b0})),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  // Descriptor for the current emitting state.
  always_comb begin
    d_x = x_q; d_y = y_q; d_w = xspan; d_h = h_q; d_last = 1'b0;
    unique case (state_q)
      S_LEAD: begin d_w = CW'(1); d_last = (w_q == CW'(1)); end
      S_MIDA: begin d_h = ytop_q; end
      S_MIDB: begin d_y = y_q + ytop_q; d_h = h_q - ytop_q; d_last = !w_q[0]; end
      S_MID:  begin d_last = !w_q[0]; end
      S_TAIL: begin d_x = x_q + w_q - CW'(1); d_w = CW'(1); d_last = 1'b1; end
      default: ;
    endcase
  end

  assign load = slot_free &&
                (state_q inside {S_LEAD, S_MIDA, S_MIDB, S_MID, S_TAIL});

  rs_out_slot #(.DW(DW)) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .data_i  ({d_x, d_y, d_w, d_h, mode_q, first_q, d_last}),
    .free_o  (slot_free),
    .valid_o (slot_valid),
    .ready_i (desc_ready_i),
    .data_o  (slot_out)
  );

  assign req_ready_o = (state_q == S_IDLE) && !slot_valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      w_q     <= '0;
      h_q     <= '0;
      ytop_q  <= '0;
      mode_q  <= '0;
      first_q <= 1'b0;
      max_q   <= '0;
    end else begin
      if (load) first_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid_i && req_ready_o) begin
          x_q     <= req_x_i;
          y_q     <= req_y_i;
          w_q     <= req_w_i;
          h_q     <= req_h_i;
          mode_q  <= req_mode_i;
          first_q <= req_tsync_i;
          max_q   <= max_len_i;
          state_q <= S_PLAN;
        end
        S_PLAN: begin
          if (!mode_ok(mode_q))               state_q <= S_ERR;
          else if (w_q == '0 || h_q == '0)    state_q <= S_EMPTY;
          else if (x_q[0])                    state_q <= S_LEAD;
          else                                state_q <= S_MCHK;
        end
        S_LEAD: if (load) begin
          x_q     <= x_q + CW'(1);
          w_q     <= w_q - CW'(1);
          state_q <= (w_q == CW'(1)) ? S_IDLE : S_MCHK;
        end
        S_MCHK: begin
          if (xspan == '0)   state_q <= S_TAIL;
          else if (oversize) state_q <= S_DIV;
          else               state_q <= S_MID;
        end
        S_DIV: if (div_done) begin
          ytop_q  <= (div_quot == '0) ? CW'(1) : CW'(div_quot);
          state_q <= S_MIDA;
        end
        S_MIDA: if (load) state_q <= S_MIDB;
        S_MIDB, S_MID: if (load) state_q <= w_q[0] ? S_TAIL : S_IDLE;
        S_TAIL: if (load) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= (slot_valid && desc_ready_i && slot_out[0]) ||
                (state_q == S_EMPTY) || (state_q == S_ERR);
      err_q  <= (state_q == S_ERR);
    end
  end

  assign desc_valid_o = slot_valid;
  assign {desc_x_o, desc_y_o, desc_w_o, desc_h_o, desc_mode_o, desc_tsync_o, desc_last_o} = slot_out;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/rect_splitter_chk.sv
module rect_splitter_chk #(
  parameter int CW = 11,
  parameter int LW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          desc_valid_o,
  input logic          desc_ready_i,
  input logic [CW-1:0] desc_x_o,
  input logic [CW-1:0] desc_y_o,
  input logic [CW-1:0] desc_w_o,
  input logic [CW-1:0] desc_h_o,
  input logic [1:0]    desc_mode_o,
  input logic          desc_tsync_o,
  input logic          desc_last_o,
  input logic          done_o,
  input logic          err_o
);
  logic emitted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           emitted_q <= 1'b0;
    else if (req_valid_i && req_ready_o)   emitted_q <= 1'b0;
    else if (desc_valid_o && desc_ready_i) emitted_q <= 1'b1;
  end

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && !desc_ready_i |=> desc_valid_o && $stable(desc_x_o) && $stable(desc_y_o)
      && $stable(desc_w_o) && $stable(desc_h_o) && $stable(desc_tsync_o) && $stable(desc_last_o));

  // R2 R3 R5: every piece is one column or an even span
  a_r3_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> (desc_w_o == CW'(1)) || (desc_w_o[0] == 1'b0 && desc_w_o != '0));

  a_r4_nonzero_h: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> desc_h_o != '0);

  a_r6_tsync_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o && emitted_q |-> !desc_tsync_o);

  a_r7_mode_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |-> desc_mode_o != 2'd3);

  a_r7_err_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !desc_valid_o);

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind rect_splitter rect_splitter_chk #(.CW(CW), .LW(LW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .desc_valid_o (desc_valid_o),
  .desc_ready_i (desc_ready_i),
  .desc_x_o     (desc_x_o),
  .desc_y_o     (desc_y_o),
  .desc_w_o     (desc_w_o),
  .desc_h_o     (desc_h_o),
  .desc_mode_o  (desc_mode_o),
  .desc_tsync_o (desc_tsync_o),
  .desc_last_o  (desc_last_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/rect_splitter_bench.sv
module rect_splitter_bench;
  localparam int CW = 11;
  localparam int LW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [CW-1:0] req_x = '0, req_y = '0, req_w = '0, req_h = '0;
  logic [1:0]    req_mode = '0;
  logic          req_tsync = 1'b0;
  logic [LW-1:0] max_len = '0;
  logic          desc_valid, desc_ready = 1'b0;
  logic [CW-1:0] dx, dy, dw, dh;
  logic [1:0]    dmode;
  logic          dts, dlast, done, err;

  always #4 clk = !clk;

  rect_splitter #(.CW(CW), .LW(LW)) u_rect_splitter (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_x_i(req_x), .req_y_i(req_y), .req_w_i(req_w), .req_h_i(req_h),
    .req_mode_i(req_mode), .req_tsync_i(req_tsync), .max_len_i(max_len),
    .desc_valid_o(desc_valid), .desc_ready_i(desc_ready),
    .desc_x_o(dx), .desc_y_o(dy), .desc_w_o(dw), .desc_h_o(dh),
    .desc_mode_o(dmode), .desc_tsync_o(dts), .desc_last_o(dlast),
    .done_o(done), .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  int unsigned seed = 32'h1d2c3b4a;
  int stall_pct = 30;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected pieces
  longint e_x[4], e_y[4], e_w[4], e_h[4];
  bit     e_ts[4];
  int     e_n;
  bit     e_err;

  task automatic add_piece(input longint x, input longint y, input longint w, input longint h, input bit ts);
    e_x[e_n] = x; e_y[e_n] = y; e_w[e_n] = w; e_h[e_n] = h;
    e_ts[e_n] = (e_n == 0) ? ts : 1'b0;
    e_n++;
  endtask

  task automatic build_exp(input longint x, input longint y, input longint w, input longint h,
                           input int mode, input bit ts, input longint mx);
    longint cx, cw, xs, ys;
    e_n = 0;
    e_err = (mode == 3);
    if (e_err || w == 0 || h == 0) return;
    cx = x; cw = w;
    if (cx % 2 == 1) begin add_piece(cx, y, 1, h, ts); cx++; cw--; end
    xs = cw - (cw % 2);
    if (xs != 0) begin
      if (xs * h * 2 > mx && h > 1) begin
        ys = mx / (xs * 2);
        if (ys == 0) ys = 1;
        add_piece(cx, y, xs, ys, ts);
        add_piece(cx, y + ys, xs, h - ys, ts);
      end else add_piece(cx, y, xs, h, ts);
      cx += xs; cw -= xs;
    end
    if (cw != 0) add_piece(cx, y, 1, h, ts);
  endtask

  // received pieces
  longint g_x[8], g_y[8], g_w[8], g_h[8];
  bit     g_ts[8], g_last[8];
  int     g_mode[8];
  int     g_n, done_cnt, err_cnt;
  bit     hold_prev = 1'b0;
  logic [4*CW+3:0] hold_val;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_prev && desc_valid)
        chk({dx, dy, dw, dh, dmode, dts, dlast} == hold_val, "R10 held descriptor changed", dx, hold_val[4*CW+3 -: CW]);
      desc_ready = (($urandom(seed) % 100) >= stall_pct);
      seed = seed + 1;
      if (desc_valid && desc_ready && g_n < 8) begin
        g_x[g_n] = dx; g_y[g_n] = dy; g_w[g_n] = dw; g_h[g_n] = dh;
        g_ts[g_n] = dts; g_last[g_n] = dlast; g_mode[g_n] = dmode;
        g_n++;
      end
      hold_prev = desc_valid && !desc_ready;
      hold_val  = {dx, dy, dw, dh, dmode, dts, dlast};
      if (done) begin
        done_cnt++;
        chk(!desc_valid, "R9 descriptor valid during done", 1, 0);
      end
      if (err) err_cnt++;
    end
  end

  task automatic run_req(input int x, input int y, input int w, input int h,
                         input int mode, input bit ts, input int mx);
    build_exp(x, y, w, h, mode, ts, mx);
    g_n = 0; done_cnt = 0; err_cnt = 0;
    @(negedge clk);
    req_x = CW'(x); req_y = CW'(y); req_w = CW'(w); req_h = CW'(h);
    req_mode = 2'(mode); req_tsync = ts; max_len = LW'(mx); req_valid = 1'b1;
    #1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
    for (int i = 0; i < 400 && done_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R9 done pulse count", done_cnt, 1);
    chk(err_cnt == int'(e_err), "R7 err pulse", err_cnt, e_err);
    chk(g_n == e_n, (e_n == 0) ? "R8 no descriptor expected" : "R3 piece count", g_n, e_n);
    for (int i = 0; i < e_n && i < g_n; i++) begin
      chk(g_x[i] == e_x[i], "R2 piece x", g_x[i], e_x[i]);
      chk(g_y[i] == e_y[i], "R4 piece y", g_y[i], e_y[i]);
      chk(g_w[i] == e_w[i], "R3 piece width", g_w[i], e_w[i]);
      chk(g_h[i] == e_h[i], "R4 piece height", g_h[i], e_h[i]);
      chk(g_ts[i] == e_ts[i], "R6 tsync", g_ts[i], e_ts[i]);
      chk(g_mode[i] == mode, "R7 mode passthrough", g_mode[i], mode);
      chk(g_last[i] == (i == e_n - 1), "R9 last flag", g_last[i], i == e_n - 1);
    end
  endtask

  int cycles = 0;
  bit wd_fired = 1'b0;
  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000 && !wd_fired) begin
      wd_fired = 1'b1;
      chk(1'b0, "watchdog expired", cycles, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!desc_valid, "R1 reset desc_valid", desc_valid, 0);
    chk(!done && !err, "R1 reset done/err", {done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 req_ready after reset", req_ready, 1);
    chk(!desc_valid, "R1 idle desc_valid", desc_valid, 0);

    // directed corners
    run_req(5, 7, 1, 9, 0, 1, 100000);    // R2 single odd column
    run_req(3, 2, 2, 4, 1, 1, 100000);    // R2 R5 lead + tail
    run_req(4, 0, 5, 6, 2, 1, 100000);    // R3 R5 even span + tail
    run_req(1, 1, 4, 3, 0, 1, 100000);    // R2 R3 R5
    run_req(0, 0, 0, 8, 0, 1, 100000);    // R8 zero width
    run_req(2, 2, 8, 0, 1, 0, 100000);    // R8 zero height
    run_req(2, 2, 8, 8, 3, 1, 100000);    // R7 rejected mode
    run_req(0, 10, 10, 20, 0, 1, 400);    // R3 budget exactly met
    run_req(0, 10, 10, 20, 0, 1, 399);    // R4 one byte over
    run_req(1, 3, 101, 50, 2, 1, 50);     // R4 quotient zero
    run_req(6, 4, 40, 1, 1, 1, 10);       // R4 height one never split
    stall_pct = 90;
    run_req(7, 9, 33, 17, 0, 1, 300);     // R10 heavy stall
    stall_pct = 30;

    for (int k = 0; k < 300; k++) begin
      int x, y, w, h, m, mx;
      x  = $urandom(seed + k * 7 + 1) % 1024;
      y  = $urandom(seed + k * 7 + 2) % 1024;
      w  = $urandom(seed + k * 7 + 3) % ((k % 3 == 0) ? 8 : 1024);
      h  = $urandom(seed + k * 7 + 4) % ((k % 4 == 0) ? 4 : 1024);
      m  = $urandom(seed + k * 7 + 5) % 4;
      mx = $urandom(seed + k * 7 + 6) % ((k % 2 == 0) ? 4096 : 1048576);
      stall_pct = $urandom(seed + k * 7 + 7) % 80;
      run_req(x, y, w, h, m, k[0], mx);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule